// File: doc/BRIEF.md
# SDRAM Bank Command Checker

This block watches the command bus between a memory controller and a four-bank synchronous DRAM. Each cycle it decodes the command code, the two bank-select bits and the A10 line. It keeps a per-bank view of which rows are open, which bank is finishing a burst that ends in an automatic precharge, and which banks are still waiting out the row-precharge time. Any command that breaks these rules is reported with a one-cycle violation pulse and a cause code. The offending command is treated as if it never happened, so later checks stay coherent.

Alongside the protocol checks, the block derives the data-path masking implied by the byte-mask input. During write beats a byte lane is discarded in the same cycle that its mask bit is high. During read beats a lane is turned off two cycles after its mask bit was sampled. A system places the checker next to the controller to catch ordering bugs, or uses its mask and output-enable outputs to gate the data path.

Top module: `sdram_bank_guard`

## Requirements
- R1: Command codes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, BURST-STOP=5. The bank bits select bank 0 to 3 as their binary value. An accepted ACTIVATE raises `busy_o` bit `bank_i` from the next cycle on.
- R2: A PRECHARGE with `a10_i` high ignores `bank_i` and closes every open bank. Each of these banks becomes idle once the recovery time has passed.
- R3: While a READ or WRITE burst with automatic precharge (A10 high) is in progress, any READ or WRITE, to any bank, is rejected with cause 1.
- R4: A READ or WRITE sampled in the cycle after the last beat of an auto-precharge burst is accepted.
- R5: If a bank's auto-precharge burst ends at edge e, an ACTIVATE to that bank before edge e+TRP is rejected with cause 2, and one at edge e+TRP is accepted. A single-beat auto-precharge command counts as ending at its own edge.
- R6: BURST-STOP ends the running burst at any burst length. It is never a violation, and with no burst running it has no effect.
- R7: The burst-length select encodes 0,1,2,3 as 1,2,4,8 beats. In every write beat cycle `wr_mask_o` equals `dqm_i` in the same cycle. Outside write beats it is zero.
- R8: `rd_oe_o` bit i is high exactly two cycles after a read beat cycle whose sampled `dqm_i` bit i was low.
- R9: A READ or WRITE to a bank with no open row gets cause 4. An ACTIVATE to a bank that is open or in an auto-precharge burst gets cause 3. A PRECHARGE that covers a bank in an auto-precharge burst gets cause 5. A rejected command changes no state.
- R10: `viol_o` is a one-cycle pulse in the cycle after the offending command, and `cause_o` carries its code. When no violation is flagged, `cause_o` is 0.
- R11: After reset all banks are idle, no burst runs, and `viol_o`, `cause_o` and `rd_oe_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Decoded command code |
| bank_i | input | BA_W | Bank select bits |
| a10_i | input | 1 | Auto-precharge flag for READ/WRITE, all-bank flag for PRECHARGE |
| bl_sel_i | input | BL_SEL_W | Burst length select (1,2,4,8 beats) |
| dqm_i | input | LANES | Per-lane data mask |
| busy_o | output | 2**BA_W | Per-bank busy (open, bursting or recovering) |
| viol_o | output | 1 | Violation pulse |
| cause_o | output | 3 | Violation cause code |
| wr_mask_o | output | LANES | Write lanes discarded this cycle |
| rd_oe_o | output | LANES | Read lanes driven this cycle |

## Verification
On every cycle the assertions check several relationships. A violation always carries a non-zero code, and a quiet cycle carries code zero. An auto-precharge block or a recovery fault always follows a command of the matching kind. A burst stop never flags. An accepted activate of an idle bank shows it busy on the next cycle. Read enables never appear for a lane that was masked two cycles earlier.

Some behaviours depend on history and only the bench's scenarios can show them. These are the exact edge at which recovery ends, whether a precharge to all banks really ignores the bank bits, whether a burst stop cuts read enables and write masks short, and whether a rejected command leaves the bank view untouched. The bench compares all outputs against its reference model on every cycle.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_BST = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_AP_BURST = 3'd1,
    CAUSE_TRP      = 3'd2,
    CAUSE_ROW_OPEN = 3'd3,
    CAUSE_ROW_SHUT = 3'd4,
    CAUSE_PRE_AP   = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_APBURST = 2'd2,
    BK_RECOV   = 2'd3
  } bank_st_e;
endpackage

// File: rtl/sbg_bank.sv
module sbg_bank
  import sbg_pkg::*;
#(
  parameter int TRP = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     act_go,
  input  logic     pre_go,
  input  logic     ap_go,
  input  logic     ap_single,
  input  logic     ap_end,
  output bank_st_e st_o,
  output logic     rec_done_o
);
  localparam int CNT_W = (TRP > 1) ? $clog2(TRP) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRP - 1);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      BK_IDLE: begin
        if (act_go) st_d = BK_OPEN;
      end
      BK_OPEN: begin
        if (pre_go || (ap_go && ap_single)) begin
          st_d  = BK_RECOV;
          cnt_d = CNT_LOAD;
        end else if (ap_go) begin
          st_d = BK_APBURST;
        end
      end
      BK_APBURST: begin
        if (ap_end) begin
          st_d  = BK_RECOV;
          cnt_d = CNT_LOAD;
        end
      end
      default: begin
        if (act_go)                st_d  = BK_OPEN;
        else if (cnt_q == '0)      st_d  = BK_IDLE;
        else                       cnt_d = cnt_q - 1'b1;
      end
    endcase
  end

  assign upd_en = (st_d != st_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign st_o       = st_q;
  assign rec_done_o = (cnt_q == '0);
endmodule

// File: rtl/sbg_burst.sv
module sbg_burst #(
  parameter int REM_W = 3,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic             start_ap,
  input  logic [BA_W-1:0]  start_bank,
  input  logic [REM_W-1:0] start_rem,
  input  logic             stop,
  output logic             live_o,
  output logic             last_o,
  output logic             wr_o,
  output logic             ap_o,
  output logic [BA_W-1:0]  bank_o
);
  logic [REM_W-1:0] rem_q, rem_d;
  logic             wr_q, wr_d, ap_q, ap_d;
  logic [BA_W-1:0]  bank_q, bank_d;
  logic             upd_en;

  always_comb begin
    rem_d  = rem_q;
    wr_d   = wr_q;
    ap_d   = ap_q;
    bank_d = bank_q;
    if (start) begin
      rem_d  = start_rem;
      wr_d   = start_wr;
      ap_d   = start_ap;
      bank_d = start_bank;
    end else if (stop) begin
      rem_d = '0;
    end else if (rem_q != '0) begin
      rem_d = rem_q - 1'b1;
    end
  end

  assign upd_en = start || (rem_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (upd_en) begin
      rem_q  <= rem_d;
      wr_q   <= wr_d;
      ap_q   <= ap_d;
      bank_q <= bank_d;
    end
  end

  assign live_o = (rem_q != '0);
  assign last_o = (rem_q == REM_W'(1));
  assign wr_o   = wr_q;
  assign ap_o   = ap_q;
  assign bank_o = bank_q;
endmodule

// File: rtl/sbg_dqm.sv
module sbg_dqm #(
  parameter int LANES  = 4,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_slot,
  input  logic             rd_slot,
  input  logic [LANES-1:0] dqm_i,
  output logic [LANES-1:0] wr_mask_o,
  output logic [LANES-1:0] rd_oe_o
);
  logic [LANES-1:0] stage_q [RD_LAT];
  logic [LANES-1:0] oe_in;

  assign wr_mask_o = wr_slot ? dqm_i : '0;
  assign oe_in     = rd_slot ? ~dqm_i : '0;

  for (genvar s = 0; s < RD_LAT; s++) begin : g_lat
    logic [LANES-1:0] src;
    if (s == 0) begin : g_head
      assign src = oe_in;
    end else begin : g_tail
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= src;
    end
  end

  assign rd_oe_o = stage_q[RD_LAT-1];
endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
  import sbg_pkg::*;
#(
  parameter int BA_W     = 2,
  parameter int BL_SEL_W = 2,
  parameter int LANES    = 4,
  parameter int TRP      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 a10_i,
  input  logic [BL_SEL_W-1:0]  bl_sel_i,
  input  logic [LANES-1:0]     dqm_i,
  output logic [(1<<BA_W)-1:0] busy_o,
  output logic                 viol_o,
  output logic [2:0]           cause_o,
  output logic [LANES-1:0]     wr_mask_o,
  output logic [LANES-1:0]     rd_oe_o
);
  localparam int NBANK = 1 << BA_W;
  localparam int REM_W = (1 << BL_SEL_W) - 1;

  cmd_e             cmd;
  cause_e           cause_d;
  bank_st_e         bank_st [NBANK];
  logic [NBANK-1:0] rec_done, in_apb, pre_mask;
  logic [NBANK-1:0] act_go, pre_go, ap_go, ap_end;
  logic             ok, act_acc, pre_acc, rdwr_acc, kill, stop, cont;
  logic             b_live, b_last, b_wr, b_ap, ap_live;
  logic [BA_W-1:0]  b_bank;
  logic [REM_W:0]   bl_pow;
  logic [REM_W-1:0] start_rem;
  logic             viol_q;
  cause_e           cause_q;

  assign cmd       = cmd_e'(cmd_i);
  assign ap_live   = b_live && b_ap;
  assign bl_pow    = (REM_W+1)'(1) << bl_sel_i;
  assign start_rem = REM_W'(bl_pow - 1'b1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign in_apb[b]   = (bank_st[b] == BK_APBURST);
    assign pre_mask[b] = a10_i || (bank_i == BA_W'(b));
    assign act_go[b]   = act_acc && (bank_i == BA_W'(b));
    assign pre_go[b]   = pre_acc && pre_mask[b];
    assign ap_go[b]    = rdwr_acc && a10_i && (bank_i == BA_W'(b));
    assign ap_end[b]   = ap_live && (b_bank == BA_W'(b)) && (b_last || cmd == CMD_BST);
    assign busy_o[b]   = (bank_st[b] != BK_IDLE);

    sbg_bank #(.TRP(TRP)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_go     (act_go[b]),
      .pre_go     (pre_go[b]),
      .ap_go      (ap_go[b]),
      .ap_single  (bl_sel_i == '0),
      .ap_end     (ap_end[b]),
      .st_o       (bank_st[b]),
      .rec_done_o (rec_done[b])
    );
  end

  // Legality of the command sampled this cycle
  always_comb begin
    cause_d = CAUSE_NONE;
    case (cmd)
      CMD_RD, CMD_WR: begin
        if (ap_live)                          cause_d = CAUSE_AP_BURST;
        else if (bank_st[bank_i] != BK_OPEN)  cause_d = CAUSE_ROW_SHUT;
      end
      CMD_ACT: begin
        if (bank_st[bank_i] == BK_OPEN || bank_st[bank_i] == BK_APBURST)
          cause_d = CAUSE_ROW_OPEN;
        else if (bank_st[bank_i] == BK_RECOV && !rec_done[bank_i])
          cause_d = CAUSE_TRP;
      end
      CMD_PRE: begin
        if (|(pre_mask & in_apb)) cause_d = CAUSE_PRE_AP;
      end
      default: cause_d = CAUSE_NONE;
    endcase
  end

  assign ok       = (cause_d == CAUSE_NONE);
  assign act_acc  = ok && (cmd == CMD_ACT);
  assign pre_acc  = ok && (cmd == CMD_PRE);
  assign rdwr_acc = ok && (cmd == CMD_RD || cmd == CMD_WR);
  assign kill     = pre_acc && b_live && pre_mask[b_bank];
  assign stop     = (cmd == CMD_BST) || kill;
  assign cont     = b_live && !rdwr_acc && (cmd != CMD_BST) && !kill;

  sbg_burst #(.REM_W(REM_W), .BA_W(BA_W)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rdwr_acc),
    .start_wr   (cmd == CMD_WR),
    .start_ap   (a10_i),
    .start_bank (bank_i),
    .start_rem  (start_rem),
    .stop       (stop),
    .live_o     (b_live),
    .last_o     (b_last),
    .wr_o       (b_wr),
    .ap_o       (b_ap),
    .bank_o     (b_bank)
  );

  sbg_dqm #(.LANES(LANES), .RD_LAT(2)) u_dqm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_slot   ((rdwr_acc && cmd == CMD_WR) || (cont && b_wr)),
    .rd_slot   ((rdwr_acc && cmd == CMD_RD) || (cont && !b_wr)),
    .dqm_i     (dqm_i),
    .wr_mask_o (wr_mask_o),
    .rd_oe_o   (rd_oe_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      viol_q  <= !ok;
      cause_q <= cause_d;
    end
  end

  assign viol_o  = viol_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
  parameter int BA_W     = 2,
  parameter int BL_SEL_W = 2,
  parameter int LANES    = 4,
  parameter int TRP      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_i,
  input logic [BA_W-1:0]      bank_i,
  input logic                 a10_i,
  input logic [BL_SEL_W-1:0]  bl_sel_i,
  input logic [LANES-1:0]     dqm_i,
  input logic [(1<<BA_W)-1:0] busy_o,
  input logic                 viol_o,
  input logic [2:0]           cause_o,
  input logic [LANES-1:0]     wr_mask_o,
  input logic [LANES-1:0]     rd_oe_o
);
  p_code_on_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (cause_o != 3'd0));

  p_quiet_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_o |-> (cause_o == 3'd0));

  p_ap_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && cause_o == 3'd1) |-> ($past(cmd_i) == 3'd2 || $past(cmd_i) == 3'd3));

  p_trp_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_o && cause_o == 3'd2) |-> ($past(cmd_i) == 3'd1));

  p_bst_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd5) |=> !viol_o);

  p_act_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1 && !busy_o[bank_i]) |=> (busy_o[$past(bank_i)] && !viol_o));

  p_rd_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe_o & $past(dqm_i, 2)) == '0);
endmodule

bind sdram_bank_guard sbg_checker #(
  .BA_W(BA_W), .BL_SEL_W(BL_SEL_W), .LANES(LANES), .TRP(TRP)
) chk_i (.*);

// File: tb/sdram_bank_guard_tb_top.sv
module sdram_bank_guard_tb_top;
  import sbg_pkg::*;

  localparam int CLK_P = 10;
  localparam int TRP   = 3;

  logic       clk;
  logic       rst_n;
  logic [2:0] cmd_i;
  logic [1:0] bank_i;
  logic       a10_i;
  logic [1:0] bl_sel_i;
  logic [3:0] dqm_i;
  logic [3:0] busy_o;
  logic       viol_o;
  logic [2:0] cause_o;
  logic [3:0] wr_mask_o;
  logic [3:0] rd_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int st [4];
  int cnt [4];
  int rem, bwr, bap, bbank, ev, ec;
  logic [3:0] p1, p2;

  sdram_bank_guard #(.BA_W(2), .BL_SEL_W(2), .LANES(4), .TRP(TRP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .a10_i(a10_i),
    .bl_sel_i(bl_sel_i), .dqm_i(dqm_i), .busy_o(busy_o), .viol_o(viol_o),
    .cause_o(cause_o), .wr_mask_o(wr_mask_o), .rd_oe_o(rd_oe_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cause_of(int c, int ba, int a10);
    if (c == 2 || c == 3) begin
      if (rem > 0 && bap != 0) return 1;
      if (st[ba] != 1) return 4;
    end else if (c == 1) begin
      if (st[ba] == 1 || st[ba] == 2) return 3;
      if (st[ba] == 3 && cnt[ba] != 0) return 2;
    end else if (c == 4) begin
      for (int b = 0; b < 4; b++)
        if ((a10 != 0 || b == ba) && st[b] == 2) return 5;
    end
    return 0;
  endfunction

  task automatic cyc(input int c, input int ba, input int a10, input int bl, input logic [3:0] dq);
    int cs, aend;
    bit acc, rdwr, kill, cont, ws, rs;
    logic [3:0] eb;
    @(negedge clk);
    cmd_i = 3'(c); bank_i = 2'(ba); a10_i = a10[0]; bl_sel_i = 2'(bl); dqm_i = dq;
    #1;
    cs   = cause_of(c, ba, a10);
    acc  = (cs == 0);
    rdwr = acc && (c == 2 || c == 3);
    kill = acc && c == 4 && rem > 0 && (a10 != 0 || ba == bbank);
    cont = rem > 0 && !rdwr && c != 5 && !kill;
    ws   = (rdwr && c == 3) || (cont && bwr != 0);
    rs   = (rdwr && c == 2) || (cont && bwr == 0);
    for (int b = 0; b < 4; b++) eb[b] = (st[b] != 0);
    chk(busy_o == eb, "R1 busy", busy_o, eb);
    chk(viol_o == ev[0], "R10 viol", viol_o, ev);
    chk(cause_o == 3'(ec), "R9 cause", cause_o, ec);
    chk(wr_mask_o == (ws ? dq : 4'h0), "R7 wr_mask", wr_mask_o, ws ? dq : 4'h0);
    chk(rd_oe_o == p2, "R8 rd_oe", rd_oe_o, p2);
    @(posedge clk);
    p2 = p1;
    p1 = rs ? ~dq : 4'h0;
    ev = acc ? 0 : 1;
    ec = cs;
    aend = (rem > 0 && bap != 0 && (rem == 1 || c == 5)) ? bbank : -1;
    for (int b = 0; b < 4; b++)
      if (st[b] == 3) begin
        if (cnt[b] == 0) st[b] = 0; else cnt[b]--;
      end
    if (aend >= 0) begin st[aend] = 3; cnt[aend] = TRP - 1; end
    if (rdwr) begin
      rem = (1 << bl) - 1; bwr = (c == 3); bap = a10; bbank = ba;
      if (a10 != 0) begin
        if (bl == 0) begin st[ba] = 3; cnt[ba] = TRP - 1; end
        else st[ba] = 2;
      end
    end else if (c == 5 || kill) rem = 0;
    else if (rem > 0) rem--;
    if (acc && c == 1) st[ba] = 1;
    if (acc && c == 4)
      for (int b = 0; b < 4; b++)
        if ((a10 != 0 || b == ba) && st[b] == 1) begin st[b] = 3; cnt[b] = TRP - 1; end
  endtask

  task automatic lit_viol(input int expc, input string tag);
    #2;
    chk(viol_o == (expc != 0) && cause_o == 3'(expc), tag, cause_o, expc);
  endtask

  task automatic lit_busy(input logic [3:0] expb, input string tag);
    #2;
    chk(busy_o == expb, tag, busy_o, expb);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_i = 3'd0; bank_i = 2'd0; a10_i = 1'b0; bl_sel_i = 2'd0; dqm_i = 4'hF;
    for (int b = 0; b < 4; b++) begin st[b] = 0; cnt[b] = 0; end
    rem = 0; bwr = 0; bap = 0; bbank = 0; ev = 0; ec = 0; p1 = 4'h0; p2 = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R11: reset state
    chk(busy_o == 4'h0, "R11 busy", busy_o, 0);
    chk(viol_o == 1'b0 && cause_o == 3'd0, "R11 viol", cause_o, 0);
    chk(rd_oe_o == 4'h0, "R11 rd_oe", rd_oe_o, 0);

    // R1: bank decode
    cyc(1, 0, 0, 0, 4'h0); lit_busy(4'b0001, "R1 act bank0");
    cyc(1, 3, 0, 0, 4'h0); lit_busy(4'b1001, "R1 act bank3");
    cyc(1, 1, 0, 0, 4'h0); cyc(1, 2, 0, 0, 4'h0); lit_busy(4'b1111, "R1 all open");

    // R7: write burst of 4 with changing masks
    cyc(3, 0, 0, 2, 4'h0); cyc(0, 0, 0, 0, 4'h3); cyc(0, 0, 0, 0, 4'hC);
    cyc(0, 0, 0, 0, 4'h6); cyc(0, 0, 0, 0, 4'h9);

    // R8: read burst of 4, mask applied two cycles later
    cyc(2, 3, 0, 2, 4'h1); cyc(0, 0, 0, 0, 4'h0); cyc(0, 0, 0, 0, 4'hF);
    cyc(0, 0, 0, 0, 4'h4); cyc(0, 0, 0, 0, 4'h0); cyc(0, 0, 0, 0, 4'h0);

    // R3, R4, R5: auto-precharge read on bank1
    cyc(2, 1, 1, 2, 4'h0);
    cyc(2, 3, 0, 0, 4'h0); lit_viol(1, "R3 read during ap burst");
    cyc(3, 0, 0, 0, 4'h0); lit_viol(1, "R3 write during ap burst");
    cyc(0, 0, 0, 0, 4'h0);
    cyc(2, 3, 0, 0, 4'h0); lit_viol(0, "R4 read after ap burst");
    cyc(1, 1, 0, 0, 4'h0); lit_viol(2, "R5 early activate");
    cyc(1, 1, 0, 0, 4'h0); lit_viol(0, "R5 activate at trp");

    // R6: burst stop on a length-8 read, then on an idle bus
    cyc(2, 0, 0, 3, 4'h0); cyc(0, 0, 0, 0, 4'h0); cyc(0, 0, 0, 0, 4'h0);
    cyc(5, 0, 0, 0, 4'h0); lit_viol(0, "R6 stop mid burst");
    cyc(0, 0, 0, 0, 4'h0); cyc(0, 0, 0, 0, 4'h0); cyc(0, 0, 0, 0, 4'h0);
    cyc(5, 2, 0, 0, 4'h0); lit_viol(0, "R6 stop with no burst");

    // R5 with R6: stopped auto-precharge write on bank2
    cyc(3, 2, 1, 3, 4'h2); cyc(0, 0, 0, 0, 4'h1);
    cyc(5, 0, 0, 0, 4'h0);
    cyc(1, 2, 0, 0, 4'h0); lit_viol(2, "R5 activate after stopped ap");
    cyc(0, 0, 0, 0, 4'h0);
    cyc(1, 2, 0, 0, 4'h0); lit_viol(0, "R5 activate after stop plus trp");

    // R9: rejected commands
    cyc(4, 1, 0, 0, 4'h0); lit_viol(0, "R9 precharge bank1");
    cyc(2, 1, 0, 0, 4'h0); lit_viol(4, "R9 read closed bank");
    cyc(1, 0, 0, 0, 4'h0); lit_viol(3, "R9 activate open bank");
    cyc(2, 3, 1, 2, 4'h0);
    cyc(4, 0, 1, 0, 4'h0); lit_viol(5, "R9 precharge ap bank");
    cyc(0, 0, 0, 0, 4'h0); cyc(0, 0, 0, 0, 4'h0);

    // R2: precharge all with nonzero bank bits
    cyc(4, 2, 1, 0, 4'h0);
    cyc(0, 0, 0, 0, 4'h0); cyc(0, 0, 0, 0, 4'h0);
    cyc(0, 0, 0, 0, 4'h0); cyc(0, 0, 0, 0, 4'h0);
    lit_busy(4'b0000, "R2 all banks closed");

    // R5: single-beat auto-precharge write
    cyc(1, 0, 0, 0, 4'h0);
    cyc(3, 0, 1, 0, 4'h5); lit_busy(4'b0001, "R5 single beat recovering");
    cyc(1, 0, 0, 0, 4'h0); lit_viol(2, "R5 activate after single beat");
    repeat (4) cyc(0, 0, 0, 0, 4'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule